// File: doc/BRIEF.md
# Nibble-Coded Sequencer Control Core

This block is the control engine of a small sequencer. It reads a program from a 64-bit-wide code memory and treats each word as sixteen 4-bit units. Instructions take between one and five of these units: an opcode followed by operand nibbles. The core collects the operand nibbles of each instruction and then carries the instruction out. Instructions can set the pattern pointer and four configuration registers, step the pointer up or down, branch on an external control bit, call and return, run counted loops, and wait for a number of system clocks or microseconds.

The code memory sits outside the block and is read synchronously: the word at `code_addr` appears on `code_word` one clock later, so a block RAM fits directly. The return-address stack and the loop stack are also external. The core drives them with one-cycle strobes and reads their top entries combinationally.

The program counter is a 12-bit nibble address. Its upper 8 bits select the word and its lower 4 bits select the nibble, where nibble 0 is bits [3:0]. Operands are gathered most significant nibble first. An instruction may continue into the next word.

Top module: `nsq_core`

## Requirements
- R1: Opcodes are NOP=0, LPP=1, IPP=2, DPP=3, LDA=4, LMR=5, LSR=6, LCR=7, CAL=8, RET=9, JCB=A, LPB=B, LPE=C, DUS=D, DSC=E. Instruction lengths in nibbles, counting the opcode, are 1 for NOP, IPP, DPP, RET and LPE; 3 for LDA, LMR, LSR, LCR, DUS and DSC; 4 for LPP, CAL and LPB; and 5 for JCB. Nibble 0 is code_word[3:0], and operands are assembled most significant nibble first.
- R2: One nibble is consumed per clock while the word stays the same. When the program counter moves to a different word, fetching stalls for exactly one cycle, and an instruction continues correctly across the boundary.
- R3: LPP loads the pattern pointer from its 12-bit operand, reduced into 0..1535 by subtracting 1536 as many times as needed. The pointer never leaves 0..1535.
- R4: IPP adds one and DPP subtracts one from the pattern pointer, modulo 1536 (1535+1 gives 0, and 0-1 gives 1535).
- R5: LDA, LMR, LSR and LCR take an 8-bit operand. They load device address = operand[4:0], mode = operand[1:0], select = operand[6:0] and clock configuration = operand[6:0] respectively.
- R6: JCB takes a selector nibble and then a 12-bit nibble address. It jumps to that address when ctl_bits[selector] is 1, and otherwise falls through.
- R7: CAL pulses stk_push for one cycle, with stk_wdata equal to the nibble address after the CAL, and jumps to its 12-bit target. RET pulses stk_pop and jumps to stk_top. At most one stack strobe is active in any cycle.
- R8: LPB with a 12-bit count N pulses lp_push, with lp_addr_o equal to the address after the LPB and lp_cnt_o = N. At LPE, if lp_cnt_i > 1 the core pulses lp_upd with lp_cnt_o = lp_cnt_i-1 and jumps to lp_addr_i; otherwise it pulses lp_pop and falls through. The loop body therefore runs N times.
- R9: DSC with an 8-bit count N stalls fetching for exactly N clocks. Between the register load of the instruction before it and the register load of the instruction after it (all within one word), 8+N cycles pass.
- R10: DUS with count N stalls fetching for N×US_DIV clocks, giving 8+N×US_DIV cycles between the neighbouring register loads.
- R11: NOP changes no output and consumes one nibble.
- R12: Opcode F halts the core. `halted` rises and stays high until reset, and no output changes after that.
- R13: While rst is high, every register output and strobe is 0 and halted is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| code_addr | output | 8 | Code memory word address |
| code_word | input | 64 | Code word, one cycle after code_addr |
| ctl_bits | input | 16 | Control bits tested by JCB |
| stk_top | input | 12 | Top of the return stack |
| lp_addr_i | input | 12 | Top loop start address |
| lp_cnt_i | input | 12 | Top loop remaining count |
| pat_ptr | output | 11 | Pattern pointer |
| dev_addr | output | 5 | Device address register |
| mode | output | 2 | Mode register |
| sel | output | 7 | Select register |
| clk_cfg | output | 7 | Clock configuration register |
| stk_push | output | 1 | Push return address |
| stk_pop | output | 1 | Pop return stack |
| stk_wdata | output | 12 | Return address to push |
| lp_push | output | 1 | Push new loop |
| lp_upd | output | 1 | Write decremented loop count |
| lp_pop | output | 1 | Pop finished loop |
| lp_addr_o | output | 12 | Loop start address to push |
| lp_cnt_o | output | 12 | Loop count to push or write |
| halted | output | 1 | Illegal opcode reached |

## Verification
A register load is due one clock after the last operand nibble of its instruction is consumed, and each nibble takes one cycle unless the word changes. A single-word program of k instructions therefore finishes at a fixed point. The timing checks measure the cycle distance between two observed register changes, which holds 8 cycles plus the wait. This tests the wait length without depending on when the program started. The functional checks wait for `halted` and then compare the final register values, and the strobe checks count pulses seen on falling edges.

// File: rtl/nsq_pkg.sv
package nsq_pkg;
  typedef enum logic [3:0] {
    OP_NOP = 4'h0, OP_LPP = 4'h1, OP_IPP = 4'h2, OP_DPP = 4'h3,
    OP_LDA = 4'h4, OP_LMR = 4'h5, OP_LSR = 4'h6, OP_LCR = 4'h7,
    OP_CAL = 4'h8, OP_RET = 4'h9, OP_JCB = 4'hA, OP_LPB = 4'hB,
    OP_LPE = 4'hC, OP_DUS = 4'hD, OP_DSC = 4'hE, OP_BAD = 4'hF
  } op_e;

  typedef enum logic [2:0] {ST_OP, ST_ARG, ST_EXEC, ST_WAIT, ST_HALT} st_e;

  // total instruction length in nibbles, opcode included
  function automatic logic [2:0] op_len(input op_e op);
    case (op)
      OP_LPP, OP_CAL, OP_LPB:                                 op_len = 3'd4;
      OP_LDA, OP_LMR, OP_LSR, OP_LCR, OP_DUS, OP_DSC:         op_len = 3'd3;
      OP_JCB:                                                 op_len = 3'd5;
      default:                                                op_len = 3'd1;
    endcase
  endfunction
endpackage

// File: rtl/nsq_fetch.sv
module nsq_fetch #(
  parameter int WORD_W = 64,
  parameter int ADDR_W = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [WORD_W-1:0]    code_word,
  input  logic                 adv,
  input  logic                 load,
  input  logic [ADDR_W+$clog2(WORD_W/4)-1:0] load_pc,
  output logic [ADDR_W-1:0]    code_addr,
  output logic [ADDR_W+$clog2(WORD_W/4)-1:0] pc,
  output logic [3:0]           nib,
  output logic                 nib_ok
);
  localparam int IDX_W = $clog2(WORD_W / 4);
  localparam int PC_W  = ADDR_W + IDX_W;

  logic [ADDR_W-1:0] last_word;
  logic              primed;

  assign code_addr = pc[PC_W-1:IDX_W];
  assign nib_ok    = primed && (last_word == pc[PC_W-1:IDX_W]);
  assign nib       = code_word[{pc[IDX_W-1:0], 2'b00} +: 4];

  always_ff @(posedge clk) begin
    if (rst) begin
      pc        <= '0;
      last_word <= '0;
      primed    <= 1'b0;
    end else begin
      primed    <= 1'b1;
      last_word <= pc[PC_W-1:IDX_W];
      if (load)     pc <= load_pc;
      else if (adv) pc <= pc + 1'b1;
    end
  end

  // R2: a stall lasts one cycle when the counter is left alone
  a_r2_stall_one: assert property (@(posedge clk) disable iff (rst)
    (!nib_ok && !load && !adv) |=> nib_ok);
endmodule

// File: rtl/nsq_ptr.sv
module nsq_ptr #(
  parameter int PTR_W = 11,
  parameter int DEPTH = 1536
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld,
  input  logic [11:0]      ld_val,
  input  logic             inc,
  input  logic             dec,
  output logic [PTR_W-1:0] ptr
);
  localparam logic [12:0] D1 = 13'(DEPTH);
  localparam logic [12:0] D2 = 13'(2 * DEPTH);

  logic [12:0] wide;
  logic [12:0] red;

  always_comb begin
    wide = {1'b0, ld_val};
    if (wide >= D2)      red = wide - D2;
    else if (wide >= D1) red = wide - D1;
    else                 red = wide;
  end

  always_ff @(posedge clk) begin
    if (rst) ptr <= '0;
    else if (ld) ptr <= red[PTR_W-1:0];
    else if (inc) ptr <= (ptr == PTR_W'(DEPTH - 1)) ? '0 : ptr + 1'b1;
    else if (dec) ptr <= (ptr == '0) ? PTR_W'(DEPTH - 1) : ptr - 1'b1;
  end

  // R3 / R4: pointer stays inside the pattern memory
  a_r3_ptr_in_range: assert property (@(posedge clk) disable iff (rst)
    ptr < PTR_W'(DEPTH));
  a_r4_inc_wraps: assert property (@(posedge clk) disable iff (rst)
    (inc && !ld && ptr == PTR_W'(DEPTH - 1)) |=> ptr == '0);
endmodule

// File: rtl/nsq_delay.sv
module nsq_delay #(
  parameter int US_DIV = 200
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       use_us,
  input  logic [7:0] count,
  output logic       busy,
  output logic       last
);
  localparam int PRE_W = (US_DIV > 1) ? $clog2(US_DIV) : 1;

  logic [7:0]       cnt;
  logic [PRE_W-1:0] pre;
  logic             us_mode;

  assign last = busy && (pre == '0) && (cnt == 8'd1);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      cnt     <= '0;
      pre     <= '0;
      us_mode <= 1'b0;
    end else if (start && count != 8'd0) begin
      busy    <= 1'b1;
      cnt     <= count;
      us_mode <= use_us;
      pre     <= use_us ? PRE_W'(US_DIV - 1) : '0;
    end else if (busy) begin
      if (pre == '0) begin
        pre <= us_mode ? PRE_W'(US_DIV - 1) : '0;
        cnt <= cnt - 1'b1;
        if (cnt == 8'd1) busy <= 1'b0;
      end else begin
        pre <= pre - 1'b1;
      end
    end
  end

  // R10: a running wait only ends through its final tick
  a_r10_wait_holds: assert property (@(posedge clk) disable iff (rst)
    (busy && !last) |=> busy);
endmodule

// File: rtl/nsq_core.sv
module nsq_core
  import nsq_pkg::*;
#(
  parameter int US_DIV = 200,
  parameter int WORD_W = 64,
  parameter int ADDR_W = 8,
  parameter int PTR_W  = 11,
  parameter int DEPTH  = 1536
) (
  input  logic              clk,
  input  logic              rst,
  output logic [ADDR_W-1:0] code_addr,
  input  logic [WORD_W-1:0] code_word,
  input  logic [15:0]       ctl_bits,
  input  logic [11:0]       stk_top,
  input  logic [11:0]       lp_addr_i,
  input  logic [11:0]       lp_cnt_i,
  output logic [PTR_W-1:0]  pat_ptr,
  output logic [4:0]        dev_addr,
  output logic [1:0]        mode,
  output logic [6:0]        sel,
  output logic [6:0]        clk_cfg,
  output logic              stk_push,
  output logic              stk_pop,
  output logic [11:0]       stk_wdata,
  output logic              lp_push,
  output logic              lp_upd,
  output logic              lp_pop,
  output logic [11:0]       lp_addr_o,
  output logic [11:0]       lp_cnt_o,
  output logic              halted
);
  localparam int PC_W = ADDR_W + $clog2(WORD_W / 4);

  st_e              st;
  op_e              op;
  logic [15:0]      arg;
  logic [2:0]       rem;
  logic [PC_W-1:0]  pc, load_pc;
  logic [3:0]       nib;
  logic             nib_ok, adv, load;
  logic             p_ld, p_inc, p_dec;
  logic             d_start, d_busy, d_last;

  nsq_fetch #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_fetch (
    .clk, .rst, .code_word, .adv, .load, .load_pc,
    .code_addr, .pc, .nib, .nib_ok
  );

  nsq_ptr #(.PTR_W(PTR_W), .DEPTH(DEPTH)) u_ptr (
    .clk, .rst, .ld(p_ld), .ld_val(arg[11:0]), .inc(p_inc), .dec(p_dec),
    .ptr(pat_ptr)
  );

  nsq_delay #(.US_DIV(US_DIV)) u_dly (
    .clk, .rst, .start(d_start), .use_us(op == OP_DUS), .count(arg[7:0]),
    .busy(d_busy), .last(d_last)
  );

  wire exec = (st == ST_EXEC);

  always_comb begin
    adv     = nib_ok && (st == ST_OP || st == ST_ARG);
    p_ld    = exec && op == OP_LPP;
    p_inc   = exec && op == OP_IPP;
    p_dec   = exec && op == OP_DPP;
    d_start = exec && (op == OP_DUS || op == OP_DSC);
    load    = 1'b0;
    load_pc = arg[PC_W-1:0];
    if (exec) begin
      case (op)
        OP_CAL: load = 1'b1;
        OP_JCB: load = ctl_bits[arg[15:12]];
        OP_RET: begin load = 1'b1; load_pc = stk_top[PC_W-1:0]; end
        OP_LPE: begin load = lp_cnt_i > 12'd1; load_pc = lp_addr_i[PC_W-1:0]; end
        default: load = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_OP; op <= OP_NOP; arg <= '0; rem <= '0;
      dev_addr <= '0; mode <= '0; sel <= '0; clk_cfg <= '0;
      stk_push <= 1'b0; stk_pop <= 1'b0; stk_wdata <= '0;
      lp_push <= 1'b0; lp_upd <= 1'b0; lp_pop <= 1'b0;
      lp_addr_o <= '0; lp_cnt_o <= '0; halted <= 1'b0;
    end else begin
      stk_push <= 1'b0; stk_pop <= 1'b0;
      lp_push  <= 1'b0; lp_upd  <= 1'b0; lp_pop <= 1'b0;
      case (st)
        ST_OP: if (nib_ok) begin
          op  <= op_e'(nib);
          arg <= '0;
          rem <= op_len(op_e'(nib)) - 3'd1;
          if (op_e'(nib) == OP_BAD) begin
            st <= ST_HALT; halted <= 1'b1;
          end else if (op_len(op_e'(nib)) == 3'd1) st <= ST_EXEC;
          else st <= ST_ARG;
        end
        ST_ARG: if (nib_ok) begin
          arg <= {arg[11:0], nib};
          rem <= rem - 3'd1;
          if (rem == 3'd1) st <= ST_EXEC;
        end
        ST_EXEC: begin
          st <= ST_OP;
          case (op)
            OP_LDA: dev_addr <= arg[4:0];
            OP_LMR: mode     <= arg[1:0];
            OP_LSR: sel      <= arg[6:0];
            OP_LCR: clk_cfg  <= arg[6:0];
            OP_CAL: begin stk_push <= 1'b1; stk_wdata <= 12'(pc); end
            OP_RET: stk_pop <= 1'b1;
            OP_LPB: begin
              lp_push <= 1'b1; lp_addr_o <= 12'(pc); lp_cnt_o <= arg[11:0];
            end
            OP_LPE: if (lp_cnt_i > 12'd1) begin
              lp_upd <= 1'b1; lp_cnt_o <= lp_cnt_i - 12'd1;
            end else lp_pop <= 1'b1;
            OP_DUS, OP_DSC: if (arg[7:0] != 8'd0) st <= ST_WAIT;
            default: ;
          endcase
        end
        ST_WAIT: if (d_last) st <= ST_OP;
        default: st <= ST_HALT;
      endcase
    end
  end

  // R7: stack strobes never overlap
  a_r7_one_strobe: assert property (@(posedge clk) disable iff (rst)
    $onehot0({stk_push, stk_pop, lp_push, lp_upd, lp_pop}));
  // R12: halt is sticky and freezes the registers
  a_r12_halt_sticky: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted && $stable(dev_addr) && $stable(mode) && $stable(pat_ptr));
  // R9: no fetch progress while waiting
  a_r9_pc_hold_wait: assert property (@(posedge clk) disable iff (rst)
    (st == ST_WAIT) |=> $stable(pc));
  // R5: registers change only when an instruction executes
  a_r5_load_in_exec: assert property (@(posedge clk) disable iff (rst)
    !exec |=> $stable(sel) && $stable(clk_cfg));
endmodule

// File: tb/nsq_core_test.sv
module nsq_core_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [7:0]  code_addr;
  logic [63:0] code_word;
  logic [15:0] ctl_bits;
  logic [11:0] stk_top, lp_addr_i, lp_cnt_i;
  logic [10:0] pat_ptr;
  logic [4:0]  dev_addr;
  logic [1:0]  mode;
  logic [6:0]  sel, clk_cfg;
  logic        stk_push, stk_pop, lp_push, lp_upd, lp_pop, halted;
  logic [11:0] stk_wdata, lp_addr_o, lp_cnt_o;

  nsq_core #(.US_DIV(4)) uut (
    .clk, .rst, .code_addr, .code_word, .ctl_bits, .stk_top, .lp_addr_i,
    .lp_cnt_i, .pat_ptr, .dev_addr, .mode, .sel, .clk_cfg, .stk_push,
    .stk_pop, .stk_wdata, .lp_push, .lp_upd, .lp_pop, .lp_addr_o,
    .lp_cnt_o, .halted
  );

  // environment: code memory and the two stacks
  logic [63:0] mem [256];
  logic [11:0] stk_save, la, lc;
  always @(posedge clk) code_word <= mem[code_addr];
  always @(posedge clk) begin
    if (stk_push) stk_save <= stk_wdata;
    if (lp_push) begin la <= lp_addr_o; lc <= lp_cnt_o; end
    if (lp_upd) lc <= lp_cnt_o;
  end
  assign stk_top = stk_save;
  assign lp_addr_i = la;
  assign lp_cnt_i = lc;

  int tests = 0, fails = 0;
  int cyc = 0, t_mode = 0, t_sel = 0, n_push = 0, n_pop = 0;
  int n_lpush = 0, n_lupd = 0, n_lpop = 0;
  logic [11:0] push_data, lpush_addr;
  logic [1:0] pm;
  logic [6:0] ps;

  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (mode != pm) t_mode = cyc;
      if (sel != ps) t_sel = cyc;
      if (stk_push) begin n_push++; push_data = stk_wdata; end
      if (stk_pop) n_pop++;
      if (lp_push) begin n_lpush++; lpush_addr = lp_addr_o; end
      if (lp_upd) n_lupd++;
      if (lp_pop) n_lpop++;
    end
    pm = mode;
    ps = sel;
  end

  task automatic check(input string req, input int got, input int exp);
    tests++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  function automatic logic [63:0] rev(input logic [63:0] v);
    logic [63:0] r;
    for (int i = 0; i < 16; i++) r[i*4 +: 4] = v[(15-i)*4 +: 4];
    return r;
  endfunction

  task automatic run_prog(input logic [63:0] w0, w1, w2, input logic [15:0] c);
    rst = 1'b1;
    for (int i = 0; i < 256; i++) mem[i] = '1;
    mem[0] = rev(w0); mem[1] = rev(w1); mem[2] = rev(w2);
    ctl_bits = c;
    repeat (3) @(posedge clk);
    @(negedge clk);
    n_push = 0; n_pop = 0; n_lpush = 0; n_lupd = 0; n_lpop = 0;
    t_mode = 0; t_sel = 0;
    rst = 1'b0;
    for (int i = 0; i < 3000 && !halted; i++) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  localparam int NV = 8;
  localparam logic [63:0] PROG [NV] = '{
    64'h112322FFFFFFFFFF, 64'h15FF2FFFFFFFFFFF, 64'h10003FFFFFFFFFFF,
    64'h4FF5F76AB780FFFF, 64'hA300A411FF405FFF, 64'hA300A411FF405FFF,
    64'h00412FFFFFFFFFFF, 64'h17FFFFFFFFFFFFFF};
  localparam logic [15:0] CTL [NV] = '{0, 0, 0, 0, 16'h0008, 16'hFFF7, 0, 0};
  localparam logic [10:0] E_PTR [NV] = '{11'h125, 0, 11'h5FF, 0, 0, 0, 0, 11'h1FF};
  localparam logic [4:0] E_DEV [NV] = '{0, 0, 0, 5'h1F, 5'h05, 5'h11, 5'h12, 0};
  localparam logic [1:0] E_MODE [NV] = '{0, 0, 0, 3, 0, 0, 0, 0};
  localparam logic [6:0] E_SEL [NV] = '{0, 0, 0, 7'h2B, 0, 0, 0, 0};
  localparam logic [6:0] E_CLK [NV] = '{0, 0, 0, 0, 0, 0, 0, 0};
  localparam string TAG [NV] = '{"R3 R1 load/inc", "R4 inc wrap", "R4 dec wrap",
    "R5 reg loads", "R6 jump taken", "R6 not taken", "R11 nop", "R3 reduce"};

  initial begin
    ctl_bits = '0;
    for (int i = 0; i < 256; i++) mem[i] = '1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R13 reset state
    check("R13 reset regs", {pat_ptr, dev_addr, mode, sel, clk_cfg}, 0);
    check("R13 reset strobes", {stk_push, stk_pop, lp_push, lp_upd, lp_pop, halted}, 0);

    for (int v = 0; v < NV; v++) begin
      run_prog(PROG[v], '1, '1, CTL[v]);
      check(TAG[v], pat_ptr, E_PTR[v]);
      check(TAG[v], dev_addr, E_DEV[v]);
      check(TAG[v], mode, E_MODE[v]);
      check(TAG[v], sel, E_SEL[v]);
      check(TAG[v], clk_cfg, E_CLK[v]);
    end

    // R12 halt flag and frozen outputs
    run_prog(64'h4FF5F7F4015FFFFF, '1, '1, 0);
    check("R12 halted", halted, 1);
    check("R12 frozen dev", dev_addr, 5'h1F);
    repeat (20) @(negedge clk);
    check("R12 still halted", halted, 1);

    // R2 operand crossing a word boundary
    run_prog(64'h0000000000000013, 64'h45FFFFFFFFFFFFFF, '1, 0);
    check("R2 cross word", pat_ptr, 11'h345);

    // R9 system clock waits
    run_prog(64'h501E05601FFFFFFF, '1, '1, 0);
    check("R9 dsc 5", t_sel - t_mode, 13);
    run_prog(64'h501E00601FFFFFFF, '1, '1, 0);
    check("R9 dsc 0", t_sel - t_mode, 8);
    // R10 microsecond waits, divider 4
    run_prog(64'h501D03601FFFFFFF, '1, '1, 0);
    check("R10 dus 3", t_sel - t_mode, 20);

    // R7 call and return
    run_prog(64'h8020409FFFFFFFFF, '1, 64'h4079FFFFFFFFFFFF, 0);
    check("R7 final dev", dev_addr, 5'h09);
    check("R7 pushes", n_push, 1);
    check("R7 pops", n_pop, 1);
    check("R7 return addr", push_data, 4);

    // R8 counted loop
    run_prog(64'hB0032CFFFFFFFFFF, '1, '1, 0);
    check("R8 body runs", pat_ptr, 3);
    check("R8 push addr", lpush_addr, 4);
    check("R8 updates", n_lupd, 2);
    check("R8 pops", n_lpop, 1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule